// File: doc/BRIEF.md
# Multi-Channel Periodic Tick Timer

This block holds a bank of independent down-counting timer channels that share one peripheral clock. Software programs each channel with a reload value and a control word over a simple single-cycle register port. A running channel counts down to zero, then reloads itself. On that reload it raises a one-cycle trigger pulse and sets a sticky timeout flag. The flag drives the channel's interrupt line only when the channel's interrupt enable is set, so a channel with the interrupt disabled still serves as a trigger source for other hardware.

A module-wide disable bit, set at reset, freezes every channel until software clears it. Any channel except channel 0 can be switched into chained mode. In that mode it counts the expiries of the channel below it instead of clock cycles. This joins two counters into one period of up to 64 bits, for example one minute at 100 MHz. The expiry period of an unchained channel is its reload value plus one cycle, so software writes (period / clock period) - 1.

Register map, with byte addresses and a 32-bit data port. Offset 0x00 holds the global control word, whose bit 0 is the module disable. Channel c sits at base (c+1)*0x10, with these registers:
- +0x0: reload value.
- +0x4: live count, read-only.
- +0x8: control, with bit 0 run, bit 1 interrupt enable and bit 2 chain.
- +0xC: timeout flag in bit 0, cleared by writing 1.

An access whose address has bits [1:0] not equal to zero does nothing.

Top module: `ptimer_bank`

## Requirements
- R1: After reset the global control word reads 1 (module disabled), all trigger and interrupt outputs are 0, and every channel register reads 0. Writing 0 to global bit 0 lets running channels count.
- R2: While global bit 0 is 1, no channel's live count changes except on a start, and no trigger pulses occur.
- R3: An unchained running channel with reload value L pulses its trigger for one cycle every L+1 clock cycles. The first pulse appears L+1 cycles after the write that sets run.
- R4: A channel with interrupt enable (control bit 1) at 0 still pulses its trigger and sets its timeout flag at every expiry, and its interrupt output stays 0.
- R5: The timeout flag is set at every expiry and stays set until software writes 1 to flag bit 0. Writing 0 has no effect. The interrupt output equals flag AND interrupt enable.
- R6: A chained channel (control bit 2) decrements only once per trigger pulse of the channel below it. With reload values L0 below and L1 above, started together, its first trigger comes (L0+1)(L1+1)+1 cycles after the lower channel's start, and later triggers come every (L0+1)(L1+1) cycles.
- R7: A reload value written while a channel runs does not alter the current count. It takes effect at the next reload.
- R8: Clearing run freezes the live count. Setting run again restarts the count from the reload value on the writing edge.
- R9: The live count register returns the current counter value, which falls by one per counting cycle from the reload value.
- R10: Channel 0 ignores the chain bit: it counts every cycle, and its control bit 2 reads back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| trig_o | output | NUM_CH | Per-channel one-cycle expiry pulse |
| irq_o | output | NUM_CH | Per-channel interrupt request |

## Verification
The hardest situation to reach from the ports is a chained expiry that lands exactly on a lower channel's back-to-back triggers. It has to be lined up against the one-cycle lag between the two channels. The bench sweeps small reload pairs, including a lower reload of 0 that pulses every cycle, and starts the upper channel before the lower one so that both count from a known edge. It also rewrites a reload value mid-period and measures the remaining and following periods separately. That separates the old value from the deferred new one.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_FLAG  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic chain;
        logic ie;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/ptimer_regdec.sv
module ptimer_regdec
    import ptimer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 glob_wr_o,
    output logic [NUM_CH-1:0]    load_wr_o,
    output logic [NUM_CH-1:0]    ctrl_wr_o,
    output logic [NUM_CH-1:0]    flag_wr_o,
    output logic                 aligned_o,
    output logic [ADDR_W-5:0]    slot_o,
    output reg_sel_e             sel_o
);
    localparam int SLOT_W = ADDR_W - 4;

    always_comb begin
        aligned_o = (addr_i[1:0] == 2'b00);
        slot_o    = addr_i[ADDR_W-1:4];
        sel_o     = reg_sel_e'(addr_i[3:2]);
        glob_wr_o = wr_i && aligned_o && (slot_o == '0) && (addr_i[3:2] == 2'b00);
        load_wr_o = '0;
        ctrl_wr_o = '0;
        flag_wr_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_i && aligned_o && slot_o == SLOT_W'(c + 1)) begin
                load_wr_o[c] = (sel_o == REG_LOAD);
                ctrl_wr_o[c] = (sel_o == REG_CTRL);
                flag_wr_o[c] = (sel_o == REG_FLAG);
            end
        end
    end

endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
    import ptimer_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter bit CAN_CHAIN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             wr_load_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_flag_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             prev_trig_i,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] count_o,
    output ctrl_t            ctrl_o,
    output logic             flag_o,
    output logic             trig_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        ctrl_t            ctrl;
        logic             flag;
        logic             trig;
    } chan_state_t;

    chan_state_t s_d, s_q;
    ctrl_t       new_ctrl_w;
    logic        start_w;
    logic        step_w;

    always_comb begin
        new_ctrl_w = ctrl_t'(wdata_i[2:0]);
        if (!CAN_CHAIN) begin
            new_ctrl_w.chain = 1'b0;
        end
        start_w = wr_ctrl_i && new_ctrl_w.run && !s_q.ctrl.run;
        step_w  = active_i && s_q.ctrl.run && (!s_q.ctrl.chain || prev_trig_i);

        s_d      = s_q;
        s_d.trig = 1'b0;
        if (wr_load_i) begin
            s_d.load = wdata_i;
        end
        if (wr_ctrl_i) begin
            s_d.ctrl = new_ctrl_w;
        end
        if (start_w) begin
            s_d.cnt = s_q.load;
        end else if (step_w) begin
            if (s_q.cnt == '0) begin
                s_d.cnt  = s_q.load;
                s_d.trig = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (wr_flag_i && wdata_i[0]) begin
            s_d.flag = 1'b0;
        end
        if (s_d.trig) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_o  = s_q.load;
    assign count_o = s_q.cnt;
    assign ctrl_o  = s_q.ctrl;
    assign flag_o  = s_q.flag;
    assign trig_o  = s_q.trig;
    assign irq_o   = s_q.flag && s_q.ctrl.ie;

    AST_TRIG_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig |-> $past(s_q.cnt) == '0);                              // R3
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig |-> s_q.cnt == $past(s_q.load));                        // R7
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !start_w) |=> $stable(s_q.cnt));                   // R2
    AST_CHAIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.chain && !prev_trig_i && !start_w) |=> $stable(s_q.cnt)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !(wr_flag_i && wdata_i[0])) |=> s_q.flag);          // R5

endmodule

// File: rtl/ptimer_bank.sv
module ptimer_bank
    import ptimer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] trig_o,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int SLOT_W = ADDR_W - 4;

    typedef struct packed {
        logic mdis;
    } glob_state_t;

    glob_state_t g_d, g_q;

    logic              glob_wr_w;
    logic [NUM_CH-1:0] load_wr_w, ctrl_wr_w, flag_wr_w;
    logic              aligned_w;
    logic [SLOT_W-1:0] slot_w;
    reg_sel_e          sel_w;

    logic [CNT_W-1:0]  load_w  [NUM_CH];
    logic [CNT_W-1:0]  count_w [NUM_CH];
    ctrl_t             ctrl_w  [NUM_CH];
    logic [NUM_CH-1:0] flag_w;
    logic [NUM_CH:0]   chain_in_w;

    ptimer_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .glob_wr_o (glob_wr_w),
        .load_wr_o (load_wr_w),
        .ctrl_wr_o (ctrl_wr_w),
        .flag_wr_o (flag_wr_w),
        .aligned_o (aligned_w),
        .slot_o    (slot_w),
        .sel_o     (sel_w)
    );

    always_comb begin
        g_d = g_q;
        if (glob_wr_w) begin
            g_d.mdis = bus_wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.mdis <= 1'b1;
        end else begin
            g_q <= g_d;
        end
    end

    assign chain_in_w[0] = 1'b0;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ptimer_chan #(.CNT_W(CNT_W), .CAN_CHAIN(c != 0)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .active_i    (!g_q.mdis),
            .wr_load_i   (load_wr_w[c]),
            .wr_ctrl_i   (ctrl_wr_w[c]),
            .wr_flag_i   (flag_wr_w[c]),
            .wdata_i     (bus_wdata_i[CNT_W-1:0]),
            .prev_trig_i (chain_in_w[c]),
            .load_o      (load_w[c]),
            .count_o     (count_w[c]),
            .ctrl_o      (ctrl_w[c]),
            .flag_o      (flag_w[c]),
            .trig_o      (trig_o[c]),
            .irq_o       (irq_o[c])
        );
        assign chain_in_w[c+1] = trig_o[c];
    end

    always_comb begin
        bus_rdata_o = '0;
        if (aligned_w) begin
            if (slot_w == '0) begin
                if (sel_w == REG_LOAD) begin
                    bus_rdata_o[0] = g_q.mdis;
                end
            end else begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (slot_w == SLOT_W'(c + 1)) begin
                        case (sel_w)
                            REG_LOAD:  bus_rdata_o[CNT_W-1:0] = load_w[c];
                            REG_COUNT: bus_rdata_o[CNT_W-1:0] = count_w[c];
                            REG_CTRL:  bus_rdata_o[2:0]       = ctrl_w[c];
                            default:   bus_rdata_o[0]         = flag_w[c];
                        endcase
                    end
                end
            end
        end
    end

    AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.mdis |=> (trig_o == '0));                                    // R2

endmodule

// File: tb/ptimer_bank_test.sv
module ptimer_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] trig, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ptimer_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .trig_o(trig), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ra(input int ch, input int off);
        return 8'((ch + 1) * 16 + off);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_trig(input int ch, output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            #1;
        end while (!trig[ch] && n < 5000);
    endtask

    task automatic stop_all();
        for (int c = 0; c < NCH; c++) wr(ra(c, 8), 0);
        for (int c = 0; c < NCH; c++) wr(ra(c, 12), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        int n, n2;
        bit seen;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd(8'h00, d); chk(d == 1, "R1 global reset", d, 1);
        chk(trig == 0 && irq == 0, "R1 outputs idle", {trig, irq}, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(ra(c, 0), d);  chk(d == 0, "R1 load reset", d, 0);
            rd(ra(c, 8), d);  chk(d == 0, "R1 ctrl reset", d, 0);
        end

        // R2 disabled module does not count
        wr(ra(0, 0), 5);
        wr(ra(0, 8), 1);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (trig != 0) seen = 1;
        end
        rd(ra(0, 4), d); chk(d == 5, "R2 count frozen", d, 5);
        chk(!seen, "R2 no trigger while disabled", seen, 0);

        // R1 enabling starts counting
        wr(8'h00, 0);
        wait_trig(0, n); chk(n == 6, "R1 first expiry after enable", n, 6);
        stop_all();

        // R3 / R4 period sweep, interrupt disabled
        for (int L = 0; L <= 6; L++) begin
            wr(ra(0, 0), L);
            wr(ra(0, 8), 1);
            wait_trig(0, n);  chk(n == L + 1, "R3 first period", n, L + 1);
            wait_trig(0, n2); chk(n2 == L + 1, "R3 repeat period", n2, L + 1);
            chk(irq[0] == 0, "R4 no irq with ie=0", irq[0], 0);
            rd(ra(0, 12), d); chk(d == 1, "R4 flag set with ie=0", d, 1);
            stop_all();
        end

        // R5 sticky flag and interrupt
        wr(ra(1, 0), 3);
        wr(ra(1, 8), 3);
        wait_trig(1, n); chk(n == 4, "R5 period", n, 4);
        chk(irq[1] == 1, "R5 irq raised", irq[1], 1);
        wr(ra(1, 8), 2);
        repeat (5) @(posedge clk); #1;
        chk(irq[1] == 1, "R5 irq sticky", irq[1], 1);
        wr(ra(1, 12), 0);
        #1 chk(irq[1] == 1, "R5 write 0 ignored", irq[1], 1);
        wr(ra(1, 12), 1);
        #1 chk(irq[1] == 0, "R5 W1C clears irq", irq[1], 0);
        rd(ra(1, 12), d); chk(d == 0, "R5 flag cleared", d, 0);
        stop_all();

        // R9 live count
        wr(ra(2, 0), 10);
        wr(ra(2, 8), 1);
        for (int k = 1; k <= 5; k++) begin
            @(posedge clk); #1;
            rd(ra(2, 4), d); chk(d == 32'(10 - k), "R9 live count", d, 10 - k);
        end
        // R8 stop and restart
        wr(ra(2, 8), 0);
        repeat (6) @(posedge clk); #1;
        rd(ra(2, 4), d); chk(d == 4, "R8 count frozen on stop", d, 4);
        wr(ra(2, 8), 1);
        rd(ra(2, 4), d); chk(d == 10, "R8 restart reloads", d, 10);
        stop_all();

        // R7 reload value change takes effect at next reload
        wr(ra(0, 0), 4);
        wr(ra(0, 8), 1);
        wait_trig(0, n); chk(n == 5, "R7 initial period", n, 5);
        wr(ra(0, 0), 7);
        wait_trig(0, n); chk(n == 4, "R7 current period unchanged", n, 4);
        wait_trig(0, n); chk(n == 8, "R7 new period", n, 8);
        stop_all();

        // R6 chained sweep
        for (int l0 = 0; l0 <= 2; l0++) begin
            for (int l1 = 0; l1 <= 2; l1++) begin
                wr(ra(0, 0), l0);
                wr(ra(1, 0), l1);
                wr(ra(1, 8), 5);
                wr(ra(0, 8), 1);
                wait_trig(1, n);
                chk(n == (l0 + 1) * (l1 + 1) + 1, "R6 chained first", n, (l0 + 1) * (l1 + 1) + 1);
                wait_trig(1, n);
                chk(n == (l0 + 1) * (l1 + 1), "R6 chained repeat", n, (l0 + 1) * (l1 + 1));
                stop_all();
            end
        end

        // R10 channel 0 ignores chain bit
        wr(ra(0, 0), 2);
        wr(ra(0, 8), 5);
        rd(ra(0, 8), d); chk(d == 1, "R10 chain bit reads 0", d, 1);
        wait_trig(0, n); chk(n == 3, "R10 unchained period", n, 3);
        stop_all();

        // R2 disable mid-run freezes
        wr(ra(3, 0), 20);
        wr(ra(3, 8), 1);
        wr(8'h00, 1);
        rd(ra(3, 4), d);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            if (trig != 0) seen = 1;
        end
        rd(ra(3, 4), d2); chk(d2 == d, "R2 frozen mid-run", d2, d);
        chk(!seen, "R2 no trigger mid-run", seen, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule